// File: doc/BRIEF.md
# Multi-Slot Cartridge Select Register

This block sits between an 8-bit host bus and an expansion chassis with several cartridge connectors. Software writes one byte to a select register. The high nibble names the slot that receives the primary cartridge-select strobe, and the same slot is the only one whose cartridge interrupt reaches the host. The low nibble names the slot that receives the secondary select strobe. Each nibble can address sixteen slots, but only the lowest few are real connectors. Some of the higher numbers act as enables for built-in peripherals: an FM synthesizer interface, a pair of serial ports and a feature block.

The feature block holds a small audio-source register. It chooses exactly one sound line to pass to the host's sound input: one of the physical slots, or the on-board synthesizer. Only one source is enabled at a time, so the sources stay isolated from each other. Software writes this register at a second bus address, and the write takes effect only while the secondary-select nibble points at the feature block. Both registers can be read back.

Top module: `slot_route_top`

## Requirements
- R1: After reset the select register reads 0x00 at address 0, so both strobes go to slot 0. The audio selector picks the synthesizer: `aud_en` is one-hot with bit PHYS set, which is bit 4 by default.
- R2: When `wr_en` is high and `reg_addr` is 0 at a rising clock edge, `wr_data` is stored. Reading address 0 returns the last value stored, with bits [7:4] as the primary slot and bits [3:0] as the secondary slot.
- R3: `slot_cts_n[k]` is low exactly when `host_cts_n` is low and bits [7:4] equal k. Every other physical slot's primary strobe is held high.
- R4: `slot_scs_n[k]` is low exactly when `host_scs_n` is low and bits [3:0] equal k. Every other physical slot's secondary strobe is held high.
- R5: A nibble value of PHYS (4) or more selects no physical connector, and all of that strobe's slot outputs stay high.
- R6: `host_cart_n` follows `slot_cart_n[k]` of the slot k named by bits [7:4]. Interrupt inputs of other slots have no effect. When bits [7:4] name a virtual slot, `host_cart_n` is high.
- R7: `snd_cs_n`, `uart_cs_n` and `feat_cs_n` go low when `host_scs_n` is low and bits [3:0] equal 4, 5 and 15 respectively. Otherwise they are high.
- R8: A write to address 1 while bits [3:0] equal 15 stores an audio code. Codes 0 to 3 choose that slot's sound line and code 4 chooses the synthesizer. `aud_en` is one-hot at the bit equal to the code, and address 1 reads back the code.
- R9: An audio write whose data exceeds 4, or that arrives while bits [3:0] are not 15, leaves the audio selection unchanged.
- R10: While `wr_en` is low, neither register changes, whatever `wr_data` and `reg_addr` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = slot select register, 1 = audio source register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Readback of the addressed register |
| host_cts_n | input | 1 | Host primary cartridge-select strobe, active low |
| host_scs_n | input | 1 | Host secondary select strobe, active low |
| host_cart_n | output | 1 | Cartridge interrupt toward the host, active low |
| slot_cts_n | output | 4 | Per-slot primary select strobes |
| slot_scs_n | output | 4 | Per-slot secondary select strobes |
| slot_cart_n | input | 4 | Per-slot cartridge interrupt inputs |
| snd_cs_n | output | 1 | Synthesizer interface enable |
| uart_cs_n | output | 1 | Serial port pair enable |
| feat_cs_n | output | 1 | Feature block enable |
| aud_en | output | 5 | One-hot audio source enables (slots 0-3, synthesizer) |

## Verification
Some properties are checked on every cycle. No physical slot ever sees more than one active strobe, and an idle host strobe leaves every slot high. A virtual slot number drives no connector and no interrupt. The peripheral enables are never active together, the audio enables stay one-hot, and the registers hold while no write is strobed. Other behaviour can only be shown by the bench's scenarios, because it needs expected values. That covers routing to the correct slot number, readback of each written byte, the interrupt coming from the named slot and from no other, and the acceptance or rejection of each audio write.

// File: rtl/slot_route_pkg.sv
package slot_route_pkg;
   typedef enum logic {
      ADDR_SLOT  = 1'b0,
      ADDR_AUDIO = 1'b1
   } reg_addr_e;
endpackage

// File: rtl/slot_sel_reg.sv
module slot_sel_reg #(
   parameter int SEL_W     = 4,
   parameter int PHYS      = 4,
   parameter int FEAT_SLOT = 15,
   localparam int DW       = 2 * SEL_W,
   localparam int AUD_W    = $clog2(PHYS + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               reg_addr,
   input  logic [DW-1:0]      wr_data,
   output logic [SEL_W-1:0]   cts_sel,
   output logic [SEL_W-1:0]   scs_sel,
   output logic [AUD_W-1:0]   aud_code,
   output logic [DW-1:0]      rd_data
);
   import slot_route_pkg::*;

   reg_addr_e addr;
   logic      aud_ok;

   assign addr   = reg_addr_e'(reg_addr);
   assign aud_ok = (scs_sel == SEL_W'(FEAT_SLOT)) && (wr_data <= DW'(PHYS));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cts_sel  <= '0;
         scs_sel  <= '0;
         aud_code <= AUD_W'(PHYS);
      end else if (wr_en) begin
         if (addr == ADDR_SLOT) begin
            cts_sel <= wr_data[DW-1:SEL_W];
            scs_sel <= wr_data[SEL_W-1:0];
         end else if (aud_ok) begin
            aud_code <= wr_data[AUD_W-1:0];
         end
      end
   end

   always_comb begin
      if (addr == ADDR_SLOT) rd_data = {cts_sel, scs_sel};
      else                   rd_data = DW'(aud_code);
   end

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(cts_sel) && $stable(scs_sel) && $stable(aud_code)));
   p_aud_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      aud_code <= AUD_W'(PHYS));
endmodule

// File: rtl/strobe_router.sv
module strobe_router #(
   parameter int SEL_W = 4,
   parameter int PHYS  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_n,
   input  logic [SEL_W-1:0] sel,
   output logic [PHYS-1:0]  slot_n
);
   for (genvar g = 0; g < PHYS; g++) begin : g_slot
      assign slot_n[g] = !(!host_n && (sel == SEL_W'(g)));
   end

   // R3 / R4: at most one slot strobed, and none while the host is idle
   p_route_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~slot_n));
   p_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      host_n |-> (&slot_n));
   p_virtual_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sel >= SEL_W'(PHYS)) |-> (&slot_n));
endmodule

// File: rtl/irq_mux.sv
module irq_mux #(
   parameter int SEL_W = 4,
   parameter int PHYS  = 4,
   localparam int PIDX_W = (PHYS > 1) ? $clog2(PHYS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel,
   input  logic [PHYS-1:0]  slot_irq_n,
   output logic             host_irq_n
);
   logic [PIDX_W-1:0] idx;
   assign idx = sel[PIDX_W-1:0];

   if (PHYS == (1 << SEL_W)) begin : g_full
      assign host_irq_n = slot_irq_n[idx];
   end else begin : g_part
      assign host_irq_n = (sel < SEL_W'(PHYS)) ? slot_irq_n[idx] : 1'b1;
   end

   p_virt_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sel >= SEL_W'(PHYS)) |-> host_irq_n);
endmodule

// File: rtl/slot_route_top.sv
module slot_route_top #(
   parameter int SEL_W     = 4,
   parameter int PHYS      = 4,
   parameter int SND_SLOT  = 4,
   parameter int UART_SLOT = 5,
   parameter int FEAT_SLOT = 15,
   localparam int DW       = 2 * SEL_W,
   localparam int AUD_W    = $clog2(PHYS + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic            reg_addr,
   input  logic [DW-1:0]   wr_data,
   output logic [DW-1:0]   rd_data,
   input  logic            host_cts_n,
   input  logic            host_scs_n,
   output logic            host_cart_n,
   output logic [PHYS-1:0] slot_cts_n,
   output logic [PHYS-1:0] slot_scs_n,
   input  logic [PHYS-1:0] slot_cart_n,
   output logic            snd_cs_n,
   output logic            uart_cs_n,
   output logic            feat_cs_n,
   output logic [PHYS:0]   aud_en
);
   if (PHYS < 2 || PHYS > (1 << SEL_W)) begin : g_bad_phys
      $error("PHYS must lie between 2 and 2**SEL_W");
   end
   if (SND_SLOT < PHYS || UART_SLOT < PHYS || FEAT_SLOT < PHYS) begin : g_bad_virt
      $error("peripheral slots must be above the physical slots");
   end
   if (SND_SLOT == UART_SLOT || SND_SLOT == FEAT_SLOT || UART_SLOT == FEAT_SLOT) begin : g_dup_virt
      $error("peripheral slots must be distinct");
   end
   if (FEAT_SLOT >= (1 << SEL_W) || SND_SLOT >= (1 << SEL_W) || UART_SLOT >= (1 << SEL_W)) begin : g_big_virt
      $error("peripheral slot out of nibble range");
   end

   logic [SEL_W-1:0] cts_sel, scs_sel;
   logic [AUD_W-1:0] aud_code;
   logic             scs_act;

   slot_sel_reg #(.SEL_W(SEL_W), .PHYS(PHYS), .FEAT_SLOT(FEAT_SLOT)) u_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
      .wr_data(wr_data), .cts_sel(cts_sel), .scs_sel(scs_sel),
      .aud_code(aud_code), .rd_data(rd_data));

   strobe_router #(.SEL_W(SEL_W), .PHYS(PHYS)) u_cts (
      .clk(clk), .rst_n(rst_n), .host_n(host_cts_n), .sel(cts_sel), .slot_n(slot_cts_n));

   strobe_router #(.SEL_W(SEL_W), .PHYS(PHYS)) u_scs (
      .clk(clk), .rst_n(rst_n), .host_n(host_scs_n), .sel(scs_sel), .slot_n(slot_scs_n));

   irq_mux #(.SEL_W(SEL_W), .PHYS(PHYS)) u_irq (
      .clk(clk), .rst_n(rst_n), .sel(cts_sel), .slot_irq_n(slot_cart_n), .host_irq_n(host_cart_n));

   assign scs_act   = !host_scs_n;
   assign snd_cs_n  = !(scs_act && scs_sel == SEL_W'(SND_SLOT));
   assign uart_cs_n = !(scs_act && scs_sel == SEL_W'(UART_SLOT));
   assign feat_cs_n = !(scs_act && scs_sel == SEL_W'(FEAT_SLOT));

   for (genvar a = 0; a <= PHYS; a++) begin : g_aud
      assign aud_en[a] = (aud_code == AUD_W'(a));
   end

   p_periph_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({~snd_cs_n, ~uart_cs_n, ~feat_cs_n}));
   p_periph_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      host_scs_n |-> (snd_cs_n && uart_cs_n && feat_cs_n));
   p_aud_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(aud_en));
endmodule

// File: tb/slot_route_top_test.sv
module slot_route_top_test;
   logic       clk = 1'b0;
   logic       rst_n, wr_en, reg_addr, host_cts_n, host_scs_n;
   logic [7:0] wr_data, rd_data;
   logic       host_cart_n, snd_cs_n, uart_cs_n, feat_cs_n;
   logic [3:0] slot_cts_n, slot_scs_n, slot_cart_n;
   logic [4:0] aud_en;
   int n_chk = 0, n_err = 0;
   bit done = 0;

   always #10 clk = ~clk;

   slot_route_top uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
      .wr_data(wr_data), .rd_data(rd_data), .host_cts_n(host_cts_n),
      .host_scs_n(host_scs_n), .host_cart_n(host_cart_n),
      .slot_cts_n(slot_cts_n), .slot_scs_n(slot_scs_n), .slot_cart_n(slot_cart_n),
      .snd_cs_n(snd_cs_n), .uart_cs_n(uart_cs_n), .feat_cs_n(feat_cs_n), .aud_en(aud_en));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] exp_vec(input logic host_n, input logic [3:0] sel);
      logic [3:0] v;
      for (int k = 0; k < 4; k++) v[k] = !(!host_n && sel == 4'(k));
      return v;
   endfunction

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; reg_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; reg_addr = 1'b0;
      #1;
   endtask

   task automatic t_reset;
      reg_addr = 1'b0; #1;
      chk("R1 slot reg", rd_data, 8'h00);
      chk("R1 audio", aud_en, 5'b10000);
      host_cts_n = 1'b0; host_scs_n = 1'b0; #1;
      chk("R1 cts slot0", slot_cts_n, 4'b1110);
      chk("R1 scs slot0", slot_scs_n, 4'b1110);
      host_cts_n = 1'b1; host_scs_n = 1'b1; #1;
   endtask

   task automatic t_route;
      logic [7:0] pats [5] = '{8'h00, 8'h12, 8'h31, 8'h23, 8'h30};
      foreach (pats[i]) begin
         wr(1'b0, pats[i]);
         chk("R2 readback", rd_data, pats[i]);
         host_cts_n = 1'b0; host_scs_n = 1'b1; #1;
         chk("R3 cts route", slot_cts_n, exp_vec(1'b0, pats[i][7:4]));
         chk("R4 scs idle", slot_scs_n, 4'hF);
         host_cts_n = 1'b1; host_scs_n = 1'b0; #1;
         chk("R4 scs route", slot_scs_n, exp_vec(1'b0, pats[i][3:0]));
         chk("R3 cts idle", slot_cts_n, 4'hF);
         host_scs_n = 1'b1; #1;
      end
   endtask

   task automatic t_virtual;
      wr(1'b0, 8'h4F);
      host_cts_n = 1'b0; host_scs_n = 1'b0; #1;
      chk("R5 cts virtual", slot_cts_n, 4'hF);
      chk("R5 scs virtual", slot_scs_n, 4'hF);
      host_cts_n = 1'b1; host_scs_n = 1'b1;
      wr(1'b0, 8'hE6);
      host_cts_n = 1'b0; host_scs_n = 1'b0; #1;
      chk("R5 cts virtual E", slot_cts_n, 4'hF);
      chk("R5 scs virtual 6", slot_scs_n, 4'hF);
      host_cts_n = 1'b1; host_scs_n = 1'b1; #1;
   endtask

   task automatic t_irq;
      wr(1'b0, 8'h20);
      slot_cart_n = 4'b1011; #1;
      chk("R6 irq selected low", host_cart_n, 1'b0);
      slot_cart_n = 4'b0100; #1;
      chk("R6 others ignored", host_cart_n, 1'b1);
      wr(1'b0, 8'h30);
      slot_cart_n = 4'b0111; #1;
      chk("R6 irq slot3", host_cart_n, 1'b0);
      wr(1'b0, 8'h50);
      slot_cart_n = 4'b0000; #1;
      chk("R6 virtual no irq", host_cart_n, 1'b1);
      slot_cart_n = 4'hF; #1;
   endtask

   task automatic t_periph;
      wr(1'b0, 8'h04);
      host_scs_n = 1'b0; #1;
      chk("R7 snd", {snd_cs_n, uart_cs_n, feat_cs_n}, 3'b011);
      host_scs_n = 1'b1; #1;
      chk("R7 idle", {snd_cs_n, uart_cs_n, feat_cs_n}, 3'b111);
      wr(1'b0, 8'h05);
      host_scs_n = 1'b0; #1;
      chk("R7 uart", {snd_cs_n, uart_cs_n, feat_cs_n}, 3'b101);
      host_scs_n = 1'b1;
      wr(1'b0, 8'h0F);
      host_scs_n = 1'b0; #1;
      chk("R7 feat", {snd_cs_n, uart_cs_n, feat_cs_n}, 3'b110);
      host_scs_n = 1'b1;
      wr(1'b0, 8'h03);
      host_scs_n = 1'b0; #1;
      chk("R7 physical none", {snd_cs_n, uart_cs_n, feat_cs_n}, 3'b111);
      host_scs_n = 1'b1; #1;
   endtask

   task automatic t_audio;
      wr(1'b0, 8'h0F);
      wr(1'b1, 8'h02);
      chk("R8 aud slot2", aud_en, 5'b00100);
      reg_addr = 1'b1; #1;
      chk("R8 aud readback", rd_data, 8'h02);
      reg_addr = 1'b0;
      wr(1'b1, 8'h00);
      chk("R8 aud slot0", aud_en, 5'b00001);
      wr(1'b1, 8'h04);
      chk("R8 aud synth", aud_en, 5'b10000);
      wr(1'b1, 8'h03);
      chk("R8 aud slot3", aud_en, 5'b01000);
   endtask

   task automatic t_audio_ignore;
      wr(1'b1, 8'h07);
      chk("R9 code 7 ignored", aud_en, 5'b01000);
      wr(1'b1, 8'h12);
      chk("R9 big byte ignored", aud_en, 5'b01000);
      wr(1'b0, 8'h00);
      wr(1'b1, 8'h01);
      chk("R9 feat unselected ignored", aud_en, 5'b01000);
      chk("R9 slot reg untouched", rd_data, 8'h00);
   endtask

   task automatic t_hold;
      wr(1'b0, 8'h21);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         wr_data = 8'h3F ^ 8'(i); reg_addr = 1'(i);
      end
      @(negedge clk); reg_addr = 1'b0; #1;
      chk("R10 slot held", rd_data, 8'h21);
      chk("R10 audio held", aud_en, 5'b01000);
   endtask

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; reg_addr = 1'b0; wr_data = 8'h00;
      host_cts_n = 1'b1; host_scs_n = 1'b1; slot_cart_n = 4'hF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1; #1;
      t_reset();
      t_route();
      t_virtual();
      t_irq();
      t_periph();
      t_audio();
      t_audio_ignore();
      t_hold();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            n_chk++; n_err++;
            $display("FAIL watchdog: actual hung expected done");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule